// File: doc/BRIEF.md
# Windowed serial signature analyzer

The block compresses the serial bit stream seen at one probed node of a board into a 16-bit signature. Four signals come from the board under test: a start marker, a stop marker, a sampling clock and the data line. Each of the first three has its own selectable active edge. All four are brought into a fast system clock domain through synchronizers. Edges are then found by comparing each synchronized level with its value one system cycle earlier.

A start event clears the signature register and opens the capture window. While the window is open, every active edge of the probe clock shifts one data bit into an internal-XOR linear feedback shift register. The feedback polynomial is x^16 + x^12 + x^9 + x^7 + 1, and the data bit is XORed into the feedback term. A stop event closes the window, freezes the signature and raises a done flag.

The frozen value is shown as four display characters. The ten decimal digits appear as themselves, and the six values above nine use letters that stay readable on seven-segment displays. A match flag compares the result with one expected value, so the fault-free signature at a node can be checked in a single step. A 16-bit register lets a faulty stream alias to the good signature with a probability of about one in 65536.

Top module: `sig_probe_analyzer`

## Requirements
- R1: After reset, `signature` is 0, `done` is 0 and `match` is 0.
- R2: A start event while no window is open sets `signature` to 0, clears `done` and opens the window. A start event is the selected edge of `probe_start`: rising when `start_rise`=1, falling when `start_rise`=0.
- R3: Each sampled bit d updates the state s as follows. Let fb = s[15] XOR d. The next state is (s shifted left by one, with 0 entering bit 0) XOR (fb ? 16'h1281 : 0). The value 16'h1281 is the set of taps at bits 12, 9, 7 and 0.
- R4: A probe clock edge samples `probe_data` only while the window is open. Clock edges outside the window, and clock edges of the inactive polarity, leave `signature` unchanged.
- R5: `clk_rise`=1 makes rising edges of `probe_clk` the sampling edges, and `clk_rise`=0 makes falling edges the sampling edges.
- R6: A stop event is the selected edge of `probe_stop`: rising when `stop_rise`=1, falling when `stop_rise`=0. The start polarity follows `start_rise` as given in R2, and the two selects act independently.
- R7: A stop event while the window is open closes it and sets `done`. `signature` and `done` then hold until the next start event.
- R8: A start event while the window is open has no effect, and sampling continues without a clear. A stop event while no window is open has no effect.
- R9: `match` is 1 exactly when `done` is 1 and `signature` equals `expected`.
- R10: `sig_chars` holds one 8-bit ASCII code per nibble, with the most significant nibble in bits [31:24]. Values 0 to 9 map to '0' to '9', and values 10 to 15 map to 'A', 'C', 'F', 'H', 'P' and 'U' in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| probe_start | input | 1 | Window start marker from the board |
| probe_stop | input | 1 | Window stop marker from the board |
| probe_clk | input | 1 | Sampling clock from the board |
| probe_data | input | 1 | Probed data line |
| start_rise | input | 1 | 1: rising start edge, 0: falling |
| stop_rise | input | 1 | 1: rising stop edge, 0: falling |
| clk_rise | input | 1 | 1: rising sampling edge, 0: falling |
| expected | input | 16 | Known-good signature |
| signature | output | 16 | Current or frozen signature |
| sig_chars | output | 32 | Four ASCII display characters |
| done | output | 1 | Window closed, signature frozen |
| match | output | 1 | Frozen signature equals expected |

## Verification
The bench builds the block with its defaults: a 16-bit register, the 16'h1281 tap set and two synchronizer stages. These values make the displayed characters exactly four and keep the cost of each probe edge to a few system cycles. As a result, random windows of up to 60 bits, across all eight edge-polarity combinations, fit easily in the run. The window length of zero and the start and stop markers that must be ignored are all covered at these settings.

// File: rtl/sig_probe_analyzer.sv
module sig_probe_analyzer #(
  parameter int SIG_W = 16,
  parameter logic [SIG_W-1:0] POLY = 16'h1281,
  parameter int SYNC = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 probe_start,
  input  logic                 probe_stop,
  input  logic                 probe_clk,
  input  logic                 probe_data,
  input  logic                 start_rise,
  input  logic                 stop_rise,
  input  logic                 clk_rise,
  input  logic [SIG_W-1:0]     expected,
  output logic [SIG_W-1:0]     signature,
  output logic [2*SIG_W-1:0]   sig_chars,
  output logic                 done,
  output logic                 match
);
  localparam int DIGITS = SIG_W / 4;

  logic [SYNC-1:0] st_s, sp_s, ck_s, dt_s;
  logic st_p, sp_p, ck_p;
  logic [SYNC:0] warm;
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_s <= '0; sp_s <= '0; ck_s <= '0; dt_s <= '0;
      st_p <= 1'b0; sp_p <= 1'b0; ck_p <= 1'b0;
      warm <= '0;
    end else begin
      st_s <= {st_s[SYNC-2:0], probe_start};
      sp_s <= {sp_s[SYNC-2:0], probe_stop};
      ck_s <= {ck_s[SYNC-2:0], probe_clk};
      dt_s <= {dt_s[SYNC-2:0], probe_data};
      st_p <= st_s[SYNC-1];
      sp_p <= sp_s[SYNC-1];
      ck_p <= ck_s[SYNC-1];
      warm <= {warm[SYNC-1:0], 1'b1};
    end
  end

  function automatic logic edge_of(logic now, logic prev, logic rise);
    return rise ? (now & ~prev) : (~now & prev);
  endfunction

  wire start_ev = warm[SYNC] & edge_of(st_s[SYNC-1], st_p, start_rise);
  wire stop_ev  = warm[SYNC] & edge_of(sp_s[SYNC-1], sp_p, stop_rise);
  wire clk_ev   = warm[SYNC] & edge_of(ck_s[SYNC-1], ck_p, clk_rise);

  wire fb = signature[SIG_W-1] ^ dt_s[SYNC-1];
  wire [SIG_W-1:0] sig_nx = {signature[SIG_W-2:0], 1'b0} ^ (fb ? POLY : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      signature <= '0;
      open_q    <= 1'b0;
      done      <= 1'b0;
    end else if (start_ev && !open_q) begin
      signature <= '0;
      open_q    <= 1'b1;
      done      <= 1'b0;
    end else if (open_q) begin
      if (clk_ev) signature <= sig_nx;
      if (stop_ev) begin
        open_q <= 1'b0;
        done   <= 1'b1;
      end
    end
  end

  assign match = done && (signature == expected);

  function automatic logic [7:0] glyph(logic [3:0] n);
    case (n)
      4'd10:   return 8'h41;
      4'd11:   return 8'h43;
      4'd12:   return 8'h46;
      4'd13:   return 8'h48;
      4'd14:   return 8'h50;
      4'd15:   return 8'h55;
      default: return 8'h30 + {4'd0, n};
    endcase
  endfunction

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign sig_chars[8*g +: 8] = glyph(signature[4*g +: 4]);
  end

  assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !open_q) |=> (signature == '0 && !done));
  assert_hold_outside_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_ev && !(start_ev && !open_q)) |=> $stable(signature));
  assert_stop_sets_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && stop_ev && !start_ev) |=> done);
  assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start_ev) |=> ($stable(signature) && done));
  assert_match_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    match |-> done);
  assert_open_excl_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(open_q && done));
endmodule

// File: tb/sig_probe_analyzer_test.sv
module sig_probe_analyzer_test;
  logic clk = 0, rst_n = 0;
  logic p_start = 0, p_stop = 0, p_clk = 0, p_data = 0;
  logic s_rise = 1, e_rise = 1, c_rise = 1;
  logic [15:0] expected = 0;
  logic [15:0] signature;
  logic [31:0] sig_chars;
  logic done, match;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [15:0] m_sig = 0;
  bit m_open = 0, m_done = 0;

  always #4 clk = ~clk;

  sig_probe_analyzer uut (
    .clk(clk), .rst_n(rst_n), .probe_start(p_start), .probe_stop(p_stop),
    .probe_clk(p_clk), .probe_data(p_data), .start_rise(s_rise),
    .stop_rise(e_rise), .clk_rise(c_rise), .expected(expected),
    .signature(signature), .sig_chars(sig_chars), .done(done), .match(match));

  function automatic logic [15:0] step(logic [15:0] s, logic d);
    logic f = s[15] ^ d;
    return {s[14:0], 1'b0} ^ (f ? 16'h1281 : 16'h0);
  endfunction

  function automatic logic [7:0] ch(logic [3:0] n);
    string alpha = "0123456789ACFHPU";
    return alpha[n];
  endfunction

  function automatic logic [31:0] chars(logic [15:0] s);
    return {ch(s[15:12]), ch(s[11:8]), ch(s[7:4]), ch(s[3:0])};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_modes(logic sr, logic er, logic cr);
    s_rise = sr; e_rise = er; c_rise = cr;
    p_start = ~sr; p_stop = ~er; p_clk = ~cr;
    settle();
  endtask

  task automatic pulse_start();
    p_start = s_rise; settle();
    if (!m_open) begin m_sig = 0; m_open = 1; m_done = 0; end
    p_start = ~s_rise; settle();
  endtask

  task automatic pulse_stop();
    p_stop = e_rise; settle();
    if (m_open) begin m_open = 0; m_done = 1; end
    p_stop = ~e_rise; settle();
  endtask

  task automatic clock_bit(logic b);
    p_data = b; settle();
    p_clk = c_rise; settle();
    if (m_open) m_sig = step(m_sig, b);
    p_clk = ~c_rise; settle();
  endtask

  task automatic check_all(string req);
    expected = m_sig; @(negedge clk);
    check({req, " signature R3"}, {16'h0, signature}, {16'h0, m_sig});
    check({req, " done R7"}, {31'h0, done}, {31'h0, m_done});
    check({req, " match R9"}, {31'h0, match}, {31'h0, m_done});
    check({req, " chars R10"}, sig_chars, chars(m_sig));
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 signature", {16'h0, signature}, 32'h0);
    check("R1 done", {31'h0, done}, 0);
    check("R1 match", {31'h0, match}, 0);
    rst_n = 1;
    settle();

    clock_bit(1); clock_bit(1);
    check("R4 clock before start", {16'h0, signature}, 32'h0);

    pulse_start();
    check("R2 start clears", {31'h0, done}, 0);
    for (int i = 0; i < 32; i++) clock_bit($urandom_range(0, 1));
    pulse_stop();
    check_all("rising run");

    expected = m_sig ^ 16'h0100; @(negedge clk);
    check("R9 mismatch", {31'h0, match}, 0);

    held = m_sig;
    for (int i = 0; i < 5; i++) clock_bit(1);
    check("R4 clock after stop", {16'h0, signature}, {16'h0, held});
    pulse_stop();
    check("R8 stop while closed sig", {16'h0, signature}, {16'h0, held});
    check("R8 stop while closed done", {31'h0, done}, 1);

    pulse_start();
    check("R2 start clears sig", {16'h0, signature}, 32'h0);
    for (int i = 0; i < 8; i++) clock_bit($urandom_range(0, 1));
    pulse_start();
    check("R8 start while open", {16'h0, signature}, {16'h0, m_sig});
    for (int i = 0; i < 8; i++) clock_bit($urandom_range(0, 1));
    pulse_stop();
    check_all("R8 continued run");

    pulse_start(); pulse_stop();
    check_all("R2 empty window");
    check("R10 zero chars", sig_chars, 32'h30303030);

    pulse_start();
    p_data = 1; settle();
    p_clk = 0; settle();
    check("R5 inactive clock edge", {16'h0, signature}, 32'h0);
    p_clk = 1; settle(); m_sig = step(m_sig, 1);
    p_clk = 0; settle();
    pulse_stop();
    check("R3 single one bit", {16'h0, signature}, 32'h1281);

    set_modes(0, 0, 0);
    pulse_start();
    for (int i = 0; i < 40; i++) clock_bit($urandom_range(0, 1));
    pulse_stop();
    check_all("R5 R6 falling run");

    set_modes(1, 0, 0);
    pulse_start();
    for (int i = 0; i < 24; i++) clock_bit($urandom_range(0, 1));
    pulse_stop();
    check_all("R6 mixed run");

    for (int r = 0; r < 10; r++) begin
      set_modes($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
      pulse_start();
      for (int i = 0; i < int'($urandom_range(1, 60)); i++) clock_bit($urandom_range(0, 1));
      pulse_stop();
      check_all("R5 R6 random run");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule